// File: doc/BRIEF.md
# Interrupt Pending and Wake Evaluator

This block decides, from a core's current control state, whether an interrupt can be taken right now and whether a halted core has a reason to resume. It reads the full status, cause, thread-context status and thread halt words, a debug-mode flag, and two configuration bits. The first configuration bit selects a level-compare mode for an external vectoring interrupt controller. The second says whether multithreading is present. It also takes a hard-interrupt request, a wake request, and the enable and activation bits of the virtual processing element that owns the thread.

Both outputs are pure combinational functions of the inputs, so a pipeline or a sleep controller can sample them in the same cycle it presents the state. In the default mode each of the eight pending lines is qualified by its own mask bit. In external-controller mode the eight pending bits form a priority level, and they are compared as an unsigned number against the eight mask bits, which form the current level.

Top module: `irq_wake_eval`

## Requirements
- R1: When status bit 0 (global interrupt enable) is 0, `irq_pending` is 0 whatever the pending lines and masks hold.
- R2: `irq_pending` is 0 when any one of these is set: status bit 1 (exception level), status bit 2 (error level), thread-context status bit 10 (thread interrupt exemption), or `debug_mode`.
- R3: With `cfg_ext_vec` = 0 and interrupts not blocked, `irq_pending` is 1 exactly when some bit is 1 in both cause[15:8] and status[15:8].
- R4: With `cfg_ext_vec` = 1 and interrupts not blocked, `irq_pending` is 1 exactly when cause[15:8], read as an unsigned number, is strictly greater than status[15:8].
- R5: Without multithreading, `has_work` is 1 exactly when `hard_req` is 1 and `irq_pending` is 1.
- R6: With `cfg_mt` = 1 and the thread active, `wake_req` = 1 drives `has_work` to 1 even when no interrupt is pending.
- R7: With `cfg_mt` = 1, `has_work` is 0 whenever `vpe_enabled` is 0, `vpe_activated` is 0, thread-context status bit 13 (thread activated) is 0, or bit 0 of `tc_halt` is 1.
- R8: With `cfg_mt` = 0, `wake_req`, `vpe_enabled`, `vpe_activated`, thread-context bit 13 and halt bit 0 have no effect on `has_work`.
- R9: Both outputs follow a change of the inputs with no clock edge in between.
- R10: Cause and status bits outside 15:8 and outside the named control bits do not change `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| status_reg | input | 32 | Status word: enable and level bits, masks in 15:8 |
| cause_reg | input | 32 | Cause word: pending lines in 15:8 |
| tc_status | input | 32 | Thread-context status: bit 10 exemption, bit 13 activated |
| tc_halt | input | 32 | Thread halt word, bit 0 = halted |
| debug_mode | input | 1 | Core is in debug mode |
| cfg_ext_vec | input | 1 | External vectoring controller: level compare mode |
| cfg_mt | input | 1 | Multithreading configured |
| hard_req | input | 1 | Hard interrupt request |
| wake_req | input | 1 | Wake request from thread scheduling |
| vpe_enabled | input | 1 | Owning processing element enabled |
| vpe_activated | input | 1 | Owning processing element activated |
| irq_pending | output | 1 | An enabled interrupt can be taken |
| has_work | output | 1 | Core should run or wake |

## Verification
The hardest case to reach is the one where the two match modes disagree on the same field values. One example is a pending field of 0x02 against a mask of 0x03: the masks overlap, so the default mode reports pending, but in level mode 2 is not above 3. The stimulus table contains such pairs, with equal and adjacent levels, so a swapped mode or a `>=` compare shows up. The multithreading gate needs a wake request with no interrupt and then each of the four activity conditions removed one at a time. The same conditions are also removed with multithreading off, to show that they are ignored there.

// File: rtl/irq_wake_pkg.sv
// Shared field positions and widths for the interrupt/wake evaluator.
// Assumes 32-bit control words with eight pending lines.
package irq_wake_pkg;
    localparam int REG_W       = 32;
    localparam int LINES       = 8;
    localparam int LINE_LSB    = 8;
    localparam int LINE_MSB    = LINE_LSB + LINES - 1;
    localparam int IE_BIT      = 0;
    localparam int EXL_BIT     = 1;
    localparam int ERL_BIT     = 2;
    localparam int IXMT_BIT    = 10;
    localparam int TC_ACT_BIT  = 13;
    localparam int HALT_BIT    = 0;

    typedef enum logic {
        MATCH_MASK  = 1'b0,
        MATCH_LEVEL = 1'b1
    } match_mode_e;

    typedef struct packed {
        logic vpe_en;
        logic vpe_act;
        logic tc_act;
        logic halted;
    } thread_state_t;
endpackage

// File: rtl/irq_block_gate.sv
// Decides whether interrupts are globally allowed. Assumes all inputs are
// already-decoded single bits; purely combinational.
module irq_block_gate (
    input  logic global_en,
    input  logic exc_level,
    input  logic err_level,
    input  logic thread_exempt,
    input  logic debug_mode,
    output logic gate_open
);
    // Any blocking condition closes the gate.
    always_comb begin
        gate_open = global_en & ~exc_level & ~err_level & ~thread_exempt & ~debug_mode;
    end

    // Guard: each single blocker must close the gate.
    always_comb begin
        if (exc_level || err_level || thread_exempt || debug_mode) begin
            a_r2_blockers_close: assert (!gate_open)
                else $error("R2: gate open while a blocker is set");
        end
    end
endmodule

// File: rtl/irq_line_match.sv
// Compares the pending lines against the masks, either line by line or as
// a priority level. Assumes both fields are LINES wide and unsigned.
module irq_line_match #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0]          pend_lines,
    input  logic [LINES-1:0]          mask_lines,
    input  irq_wake_pkg::match_mode_e mode,
    output logic                      hit
);
    logic [LINES-1:0] per_line;
    logic             any_line;
    logic             above_level;

    // One qualifying AND per interrupt line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign per_line[g] = pend_lines[g] & mask_lines[g];
    end

    // Reduce the per-line results and form the level compare.
    always_comb begin
        any_line    = |per_line;
        above_level = pend_lines > mask_lines;
    end

    // Pick the result for the configured controller mode.
    always_comb begin
        hit = (mode == irq_wake_pkg::MATCH_LEVEL) ? above_level : any_line;
    end

    // Guards: nothing pending never hits; in level mode a full mask never hits.
    always_comb begin
        if (pend_lines == '0) begin
            a_r3_idle_lines_no_hit: assert (!hit)
                else $error("R3: hit with no pending line");
        end
        if (mode == irq_wake_pkg::MATCH_LEVEL && mask_lines == '1) begin
            a_r4_top_level_no_hit: assert (!hit)
                else $error("R4: hit above the top level");
        end
    end
endmodule

// File: rtl/wake_qualifier.sv
// Forms has_work from the interrupt result, the wake request and the
// thread activity state. Assumes the activity gate applies only with MT.
module wake_qualifier (
    input  logic                          irq_ok,
    input  logic                          hard_req,
    input  logic                          wake_req,
    input  logic                          mt_on,
    input  irq_wake_pkg::thread_state_t   thr,
    output logic                          has_work
);
    logic thread_live;
    logic want_run;

    // A thread is live only with its element enabled, activated and running.
    always_comb begin
        thread_live = thr.vpe_en & thr.vpe_act & thr.tc_act & ~thr.halted;
    end

    // Combine the request sources, then apply the MT activity gate.
    always_comb begin
        want_run = hard_req & irq_ok;
        if (mt_on) begin
            has_work = (want_run | wake_req) & thread_live;
        end else begin
            has_work = want_run;
        end
    end

    // Guards: an idle thread under MT never has work; without a request or
    // an MT wake there is no work.
    always_comb begin
        if (mt_on && !thread_live) begin
            a_r7_idle_thread_sleeps: assert (!has_work)
                else $error("R7: work on an inactive thread");
        end
        if (!mt_on && !hard_req) begin
            a_r5_no_request_no_work: assert (!has_work)
                else $error("R5: work without a hard request");
        end
    end
endmodule

// File: rtl/irq_wake_eval.sv
// Top of the interrupt pending / wake evaluator. Slices the control words,
// gates the line match and qualifies wake. Purely combinational: no clock
// or reset is needed because the block holds no state.
module irq_wake_eval
    import irq_wake_pkg::*;
(
    input  logic [REG_W-1:0] status_reg,
    input  logic [REG_W-1:0] cause_reg,
    input  logic [REG_W-1:0] tc_status,
    input  logic [REG_W-1:0] tc_halt,
    input  logic             debug_mode,
    input  logic             cfg_ext_vec,
    input  logic             cfg_mt,
    input  logic             hard_req,
    input  logic             wake_req,
    input  logic             vpe_enabled,
    input  logic             vpe_activated,
    output logic             irq_pending,
    output logic             has_work
);
    logic          gate_open;
    logic          line_hit;
    match_mode_e   mode;
    thread_state_t thr;
    logic          unused_bits;

    // Fold unread word bits into one ignored signal.
    assign unused_bits = ^{status_reg[REG_W-1:LINE_MSB+1], status_reg[LINE_LSB-1:ERL_BIT+1],
                           cause_reg[REG_W-1:LINE_MSB+1], cause_reg[LINE_LSB-1:0],
                           tc_status[REG_W-1:TC_ACT_BIT+1], tc_status[TC_ACT_BIT-1:IXMT_BIT+1],
                           tc_status[IXMT_BIT-1:0], tc_halt[REG_W-1:HALT_BIT+1]};

    // Decode mode and thread activity fields.
    always_comb begin
        mode        = cfg_ext_vec ? MATCH_LEVEL : MATCH_MASK;
        thr.vpe_en  = vpe_enabled;
        thr.vpe_act = vpe_activated;
        thr.tc_act  = tc_status[TC_ACT_BIT];
        thr.halted  = tc_halt[HALT_BIT];
    end

    irq_block_gate u_gate (
        .global_en     (status_reg[IE_BIT]),
        .exc_level     (status_reg[EXL_BIT]),
        .err_level     (status_reg[ERL_BIT]),
        .thread_exempt (tc_status[IXMT_BIT]),
        .debug_mode    (debug_mode),
        .gate_open     (gate_open)
    );

    irq_line_match #(.LINES(LINES)) u_match (
        .pend_lines (cause_reg[LINE_MSB:LINE_LSB]),
        .mask_lines (status_reg[LINE_MSB:LINE_LSB]),
        .mode       (mode),
        .hit        (line_hit)
    );

    // Interrupt is pending only through an open gate.
    always_comb begin
        irq_pending = gate_open & line_hit;
    end

    wake_qualifier u_wake (
        .irq_ok   (irq_pending),
        .hard_req (hard_req),
        .wake_req (wake_req),
        .mt_on    (cfg_mt),
        .thr      (thr),
        .has_work (has_work)
    );

    // Guards at the top: global enable low never pends; an MT wake on a
    // live thread always yields work.
    always_comb begin
        if (!status_reg[IE_BIT]) begin
            a_r1_enable_low_quiet: assert (!irq_pending)
                else $error("R1: pending with enable low");
        end
        if (cfg_mt && wake_req && vpe_enabled && vpe_activated &&
            tc_status[TC_ACT_BIT] && !tc_halt[HALT_BIT]) begin
            a_r6_wake_runs: assert (has_work)
                else $error("R6: wake request ignored");
        end
    end
endmodule

// File: tb/irq_wake_eval_bench.sv
// Self-checking bench: vector table walk plus directed corner cases.
module irq_wake_eval_bench;
    logic        clk = 1'b0;
    logic [31:0] status_reg, cause_reg, tc_status, tc_halt;
    logic        debug_mode, cfg_ext_vec, cfg_mt, hard_req, wake_req;
    logic        vpe_enabled, vpe_activated;
    logic        irq_pending, has_work;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #10 clk = ~clk;

    irq_wake_eval u_irq_wake_eval (
        .status_reg(status_reg), .cause_reg(cause_reg), .tc_status(tc_status),
        .tc_halt(tc_halt), .debug_mode(debug_mode), .cfg_ext_vec(cfg_ext_vec),
        .cfg_mt(cfg_mt), .hard_req(hard_req), .wake_req(wake_req),
        .vpe_enabled(vpe_enabled), .vpe_activated(vpe_activated),
        .irq_pending(irq_pending), .has_work(has_work)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] im;
        logic [7:0] ip;
        logic ie, exl, erl, ixmt, dm, ev, mt, hard, wake, ven, vact, tca, halt;
    } row_t;

    localparam int NROWS = 18;
    //                        req  im     ip     ie exl erl ixmt dm ev mt hard wake ven vact tca halt
    localparam row_t TABLE [NROWS] = '{
        '{8'd1, 8'hFF, 8'hFF, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R1
        '{8'd2, 8'hFF, 8'hFF, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R2 exl
        '{8'd2, 8'hFF, 8'hFF, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R2 erl
        '{8'd2, 8'hFF, 8'hFF, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R2 ixmt
        '{8'd2, 8'hFF, 8'hFF, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R2 debug
        '{8'd3, 8'h0F, 8'h10, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R3 miss
        '{8'd3, 8'h81, 8'h80, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R3 hit
        '{8'd3, 8'h03, 8'h02, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R3 overlap
        '{8'd4, 8'h05, 8'h05, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R4 equal
        '{8'd4, 8'h05, 8'h06, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R4 above
        '{8'd4, 8'h03, 8'h02, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R4 overlap below
        '{8'd5, 8'h81, 8'h80, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0}, // R5 no request
        '{8'd6, 8'h00, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0}, // R6 wake
        '{8'd7, 8'h00, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0}, // R7 vpe off
        '{8'd7, 8'h00, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0}, // R7 not activated
        '{8'd7, 8'hFF, 8'hFF, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0}, // R7 tc inactive
        '{8'd7, 8'hFF, 8'hFF, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1}, // R7 halted
        '{8'd8, 8'hFF, 8'hFF, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1}  // R8 gates ignored
    };

    // Reference model written from the requirements.
    function automatic logic [1:0] model(input row_t r);
        logic pend, work;
        pend = r.ie && !r.exl && !r.erl && !r.ixmt && !r.dm &&
               (r.ev ? (r.ip > r.im) : ((r.ip & r.im) != 8'h00));
        work = r.hard && pend;
        if (r.mt) begin
            if (r.wake) work = 1'b1;
            if (!(r.ven && r.vact && r.tca && !r.halt)) work = 1'b0;
        end
        return {pend, work};
    endfunction

    task automatic drive(input row_t r, input logic [31:0] noise);
        status_reg    = (noise & 32'hFFFF_00F8) | {16'h0, r.im, 5'b0, r.erl, r.exl, r.ie};
        cause_reg     = (noise & 32'hFFFF_00FF) | {16'h0, r.ip, 8'h0};
        tc_status     = {18'h0, r.tca, 2'b0, r.ixmt, 10'h0};
        tc_halt       = {31'h0, r.halt};
        debug_mode    = r.dm;   cfg_ext_vec = r.ev; cfg_mt = r.mt;
        hard_req      = r.hard; wake_req = r.wake;
        vpe_enabled   = r.ven;  vpe_activated = r.vact;
    endtask

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        row_t r;
        logic [1:0] e;
        // Quiet state: all inputs zero, both outputs low.
        r = '0;
        @(negedge clk); drive(r, 32'h0); #2;
        check("R1", irq_pending, 1'b0, "quiet irq_pending");
        check("R5", has_work, 1'b0, "quiet has_work");

        // Table walk; each row drives on a falling edge and samples 2 ns later.
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(TABLE[i], 32'h0);
            #2;
            e = model(TABLE[i]);
            check($sformatf("R%0d row%0d", TABLE[i].req, i), irq_pending, e[1], "irq_pending");
            check($sformatf("R%0d row%0d", TABLE[i].req, i), has_work, e[0], "has_work");
        end

        // R8: without MT, halt/inactive with no interrupt and a wake gives nothing.
        r = TABLE[17]; r.hard = 1'b0;
        @(negedge clk); drive(r, 32'h0); #2;
        check("R8", has_work, 1'b0, "wake ignored without MT");

        // R10: noise outside the line fields must not create a pending interrupt.
        r = TABLE[6]; r.im = 8'h00; r.ip = 8'h00;
        @(negedge clk); drive(r, 32'hFFFF_00FF); #2;
        check("R10", irq_pending, 1'b0, "noise bits mask mode");
        r.ev = 1'b1; r.ip = 8'h01;
        drive(r, 32'hFFFF_00FF); #1;
        check("R10", irq_pending, 1'b1, "noise bits level mode");

        // R9: change inputs mid-cycle and see outputs move before any edge.
        r = TABLE[6];
        @(posedge clk); #3; drive(r, 32'h0); #1;
        check("R9", irq_pending, 1'b1, "same-cycle pending");
        r.ie = 1'b0; drive(r, 32'h0); #1;
        check("R9", irq_pending, 1'b0, "same-cycle drop");
        check("R9", has_work, 1'b0, "same-cycle work drop");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule